// File: doc/BRIEF.md
# Instruction Format Classifier

This block reads one 32-bit instruction word each clock and reports which encoding family the word belongs to. The classes are data processing, single load/store, block (multiple-register) load/store, branch, supervisor call, short multiply, long multiply and undefined. The decision looks only at the fixed bits that follow the 4-bit condition field, at the immediate flag in bit 25, and at bits 7:4. Alongside the class, the block passes the condition field through for every word, and the 24-bit call number for a supervisor call.

The decoder is combinational, and its results are registered once, so every output reflects the word presented at the previous rising edge. A front-end uses the class vector to steer each word to the right field extractor. The multiply encodings share their leading bits with data processing words whose immediate flag is clear. They are told apart by the pattern 1001 in bits 7:4, which no register-shifted operand can produce. Multiply detection therefore takes priority over the data processing match.

Top module: `instr_class_decode`

## Requirements
- R1: While rst_n is low, cls_o is 8'h80 (undefined only), cond_o is 0 and svc_num_o is 0.
- R2: Each output reflects the word on instr_i at the previous rising clock edge, and cls_o always has exactly one bit set. The bit positions are: 0 data processing, 1 single load/store, 2 block load/store, 3 branch, 4 supervisor call, 5 short multiply, 6 long multiply, 7 undefined.
- R3: A word with bits 27:26 = 00 that is not a multiply and not undefined under R10 is data processing (bit 0).
- R4: A word with bits 27:26 = 01 is single load/store (bit 1).
- R5: A word with bits 27:25 = 100 is block load/store (bit 2).
- R6: A word with bits 27:25 = 101 is a branch (bit 3), whatever the value of bit 24.
- R7: A word with bits 27:24 = 1111 is a supervisor call (bit 4), and svc_num_o equals bits 23:0. For every other class, svc_num_o is 0.
- R8: A word with bits 27:22 = 000000 and bits 7:4 = 1001 is a short multiply (bit 5).
- R9: A word with bits 27:23 = 00001 and bits 7:4 = 1001 is a long multiply (bit 6).
- R10: A word is undefined (bit 7) in either of two cases. The first is bits 27:26 = 00, bit 25 = 0 and bits 7:4 = 1001, but neither multiply prefix matches. The second is bits 27:24 = 1100, 1101 or 1110.
- R11: A word with bits 27:26 = 00, bit 25 = 1 and bits 7:4 = 1001 is data processing, never a multiply.
- R12: cond_o equals bits 31:28 of the word, for every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word to classify |
| cls_o | output | 8 | One-hot class vector, registered |
| cond_o | output | 4 | Condition field of the word, registered |
| svc_num_o | output | 24 | Call number for a supervisor call, 0 otherwise, registered |

## Verification
All three outputs are due exactly one rising edge after a word is applied. The driver applies each word on a falling edge and queues its expected class, condition and call number at the same moment. The monitor wakes a quarter period after every rising edge and pops at most one entry. The queue therefore lines each result up with the word from the edge before, and a one-cycle slip in either direction is reported as a mismatch.

// File: rtl/icd_pkg.sv
package icd_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned COND_W = 4;
    localparam int unsigned SVC_W  = 24;
    localparam int unsigned NCLS   = 8;

    localparam int unsigned CLS_DP    = 0;
    localparam int unsigned CLS_LS    = 1;
    localparam int unsigned CLS_LSM   = 2;
    localparam int unsigned CLS_BR    = 3;
    localparam int unsigned CLS_SVC   = 4;
    localparam int unsigned CLS_MUL   = 5;
    localparam int unsigned CLS_MULL  = 6;
    localparam int unsigned CLS_UNDEF = 7;

    typedef logic [NCLS-1:0] cls_vec_t;

    typedef struct packed {
        cls_vec_t          cls;
        logic [COND_W-1:0] cond;
        logic [SVC_W-1:0]  svc_num;
    } icd_out_t;

    localparam icd_out_t ICD_RESET = '{
        cls:     cls_vec_t'(1) << CLS_UNDEF,
        cond:    '0,
        svc_num: '0
    };
endpackage

// File: rtl/icd_prefix_match.sv
// Major-family match on the bits above the condition field.
module icd_prefix_match
    import icd_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              dp_space_o,
    output logic              ls_o,
    output logic              lsm_o,
    output logic              br_o,
    output logic              svc_o
);
    always_comb begin
        dp_space_o = (word_i[27:26] == 2'b00);
        ls_o       = (word_i[27:26] == 2'b01);
        lsm_o      = (word_i[27:25] == 3'b100);
        br_o       = (word_i[27:25] == 3'b101);
        svc_o      = (word_i[27:24] == 4'b1111);
    end
endmodule

// File: rtl/icd_mul_detect.sv
// Multiply detection inside the data-processing space.
module icd_mul_detect
    import icd_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              mul_o,
    output logic              mull_o,
    output logic              stray_o
);
    logic marker;

    always_comb begin
        // Register-shift operands never set bits 7 and 4 together.
        marker  = (word_i[27:26] == 2'b00) && !word_i[25] && (word_i[7:4] == 4'b1001);
        mul_o   = marker && (word_i[27:22] == 6'b000000);
        mull_o  = marker && (word_i[27:23] == 5'b00001);
        stray_o = marker && !mul_o && !mull_o;
    end
endmodule

// File: rtl/instr_class_decode.sv
module instr_class_decode
    import icd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WORD_W-1:0]     instr_i,
    output logic [NCLS-1:0]       cls_o,
    output logic [COND_W-1:0]     cond_o,
    output logic [SVC_W-1:0]      svc_num_o
);
    logic dp_space, ls_hit, lsm_hit, br_hit, svc_hit;
    logic mul_hit, mull_hit, stray_hit;

    icd_prefix_match u_prefix (
        .word_i     (instr_i),
        .dp_space_o (dp_space),
        .ls_o       (ls_hit),
        .lsm_o      (lsm_hit),
        .br_o       (br_hit),
        .svc_o      (svc_hit)
    );

    icd_mul_detect u_mul (
        .word_i  (instr_i),
        .mul_o   (mul_hit),
        .mull_o  (mull_hit),
        .stray_o (stray_hit)
    );

    icd_out_t res_d, res_q;

    always_comb begin
        res_d         = '0;
        res_d.cond    = instr_i[WORD_W-1 -: COND_W];
        if (mul_hit) begin
            res_d.cls[CLS_MUL] = 1'b1;
        end else if (mull_hit) begin
            res_d.cls[CLS_MULL] = 1'b1;
        end else if (stray_hit) begin
            res_d.cls[CLS_UNDEF] = 1'b1;
        end else if (dp_space) begin
            res_d.cls[CLS_DP] = 1'b1;
        end else if (ls_hit) begin
            res_d.cls[CLS_LS] = 1'b1;
        end else if (lsm_hit) begin
            res_d.cls[CLS_LSM] = 1'b1;
        end else if (br_hit) begin
            res_d.cls[CLS_BR] = 1'b1;
        end else if (svc_hit) begin
            res_d.cls[CLS_SVC] = 1'b1;
            res_d.svc_num      = instr_i[SVC_W-1:0];
        end else begin
            res_d.cls[CLS_UNDEF] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= ICD_RESET;
        else        res_q <= res_d;
    end

    assign cls_o     = res_q.cls;
    assign cond_o    = res_q.cond;
    assign svc_num_o = res_q.svc_num;
endmodule

// File: rtl/icd_checker.sv
module icd_checker
    import icd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] instr_i,
    input logic [NCLS-1:0]   cls_o,
    input logic [COND_W-1:0] cond_o,
    input logic [SVC_W-1:0]  svc_num_o
);
    logic primed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    assert_one_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cls_o) == 1);

    assert_cond_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> cond_o == $past(instr_i[31:28]));

    assert_svc_number_R7: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && cls_o[CLS_SVC] |-> svc_num_o == $past(instr_i[23:0]));

    assert_svc_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cls_o[CLS_SVC] |-> svc_num_o == '0);

    assert_mul_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && cls_o[CLS_MUL] |->
            ($past(instr_i[27:22]) == 6'b0) && ($past(instr_i[7:4]) == 4'b1001));

    assert_mull_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && cls_o[CLS_MULL] |->
            ($past(instr_i[27:23]) == 5'b00001) && ($past(instr_i[7:4]) == 4'b1001));

    assert_imm_not_mul_R11: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(instr_i[25]) |-> !cls_o[CLS_MUL] && !cls_o[CLS_MULL]);

    assert_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && ($past(instr_i[27:25]) == 3'b101) |-> cls_o[CLS_BR]);
endmodule

bind instr_class_decode icd_checker u_icd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .cls_o     (cls_o),
    .cond_o    (cond_o),
    .svc_num_o (svc_num_o)
);

// File: tb/test_instr_class_decode.sv
`timescale 1ns/1ps
module test_instr_class_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [7:0]  cls;
    logic [3:0]  cond;
    logic [23:0] svc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    instr_class_decode i_instr_class_decode (
        .clk(clk), .rst_n(rst_n), .instr_i(instr),
        .cls_o(cls), .cond_o(cond), .svc_num_o(svc)
    );

    typedef struct {
        logic [31:0] w;
        logic [7:0]  cls;
        logic [23:0] svc;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // Reference classifier written from the requirements.
    function automatic exp_t model(input logic [31:0] w);
        exp_t e;
        bit mark;
        e.w = w; e.svc = 24'h0;
        mark = (w[27:26] == 2'b00) && !w[25] && (w[7:4] == 4'b1001);
        if (mark && w[27:22] == 6'b0)            begin e.cls = 8'h20; e.tag = "R8";  end
        else if (mark && w[27:23] == 5'b00001)   begin e.cls = 8'h40; e.tag = "R9";  end
        else if (mark)                           begin e.cls = 8'h80; e.tag = "R10"; end
        else if (w[27:26] == 2'b00)              begin e.cls = 8'h01; e.tag = (w[25] && w[7:4] == 4'b1001) ? "R11" : "R3"; end
        else if (w[27:26] == 2'b01)              begin e.cls = 8'h02; e.tag = "R4";  end
        else if (w[27:25] == 3'b100)             begin e.cls = 8'h04; e.tag = "R5";  end
        else if (w[27:25] == 3'b101)             begin e.cls = 8'h08; e.tag = "R6";  end
        else if (w[27:24] == 4'b1111)            begin e.cls = 8'h10; e.tag = "R7"; e.svc = w[23:0]; end
        else                                     begin e.cls = 8'h80; e.tag = "R10"; end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        instr = w;
        sb.push_back(model(w));
    endtask

    // Monitor: results are due one edge after the word was applied.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(cls == e.cls, e.tag, "class", {24'h0, cls}, {24'h0, e.cls});
                chk(cond == e.w[31:28], "R12", "cond", {28'h0, cond}, {28'h0, e.w[31:28]});
                chk(svc == e.svc, "R7", "svc_num", {8'h0, svc}, {8'h0, e.svc});
                chk($countones(cls) == 1, "R2", "onehot", {24'h0, cls}, {24'h0, e.cls});
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #5;
        instr = 32'hFFFF_FFFF;
        #1;
        chk(cls == 8'h80, "R1", "reset class", {24'h0, cls}, 32'h80);
        chk(cond == 4'h0, "R1", "reset cond", {28'h0, cond}, 32'h0);
        chk(svc == 24'h0, "R1", "reset svc", {8'h0, svc}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        send(32'hE081_0002); // R3 register operand
        send(32'hE000_0011); // R3 bits 7:4 = 0001
        send(32'hE590_1000); // R4
        send(32'h5580_1004); // R4 with cond 5, R12
        send(32'hE8BD_8000); // R5
        send(32'hEA00_0010); // R6 bit24 clear
        send(32'h1BFF_FFFE); // R6 bit24 set
        send(32'hEF12_3456); // R7
        send(32'h0FFF_FFFF); // R7 max number
        send(32'hE000_0291); // R8 plain
        send(32'hE020_1392); // R8 accumulate
        send(32'hE081_0392); // R9
        send(32'hE100_0090); // R10 stray marker
        send(32'hEC00_0000); // R10 prefix 1100
        send(32'hEE00_0000); // R10 prefix 1110
        send(32'hE200_0090); // R11 immediate with 1001
        send(32'hE010_0092); // R8 with flag-set bit
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            w = $urandom;
            if (i % 3 == 0) begin
                w[27:26] = 2'b00;
                w[7:4]   = 4'b1001;
                if (i % 2 == 0) w[25] = 1'b0;
            end
            send(w);
        end
        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule